// File: doc/BRIEF.md
# Video Data-Enable Recovery from Sync Timing

This block sits between a parallel video source that sends only a pixel clock, horizontal sync, vertical sync and a 24-bit colour word (8 bits each for red, green and blue) and a TMDS-style encoder. The encoder needs an active-video flag to choose between pixel data and the two control bits. The source gives no such flag, so the block rebuilds it by counting. It counts pixels from each horizontal sync leading edge and lines from each vertical sync leading edge. It then opens a window set by parameters for the sync width, back porch and active size. The defaults describe 1280x720 at 60 Hz: lines of 1650 clocks (1280 active, 110 front porch, 40 sync, 220 back porch) and frames of 750 lines (720 active, 5 front porch, 5 sync, 20 back porch). The pixel clock is about 74.25 MHz.

The block also measures each incoming line and frame against the expected totals and keeps a lock flag. Active video is passed on only while locked. While unlocked the encoder sees control periods only. Colour, sync and active leave through the same two register stages, so they stay cycle-aligned at the output.

The stream has no valid/ready handshake and no back-pressure. A raster source cannot be stalled. Every clock carries one sample in, and two clocks later one sample comes out. The consumer must accept every cycle.

Top module: `vtr_sync_recover`

## Requirements
- R1: `rgb_o` equals `rgb_i` as sampled two clocks earlier, in every cycle whether locked or not. `hsync_o`, `vsync_o` and `active_o` have the same two-clock latency.
- R2: `SYNC_POL` sets the asserted sync level (1 = high, 0 = low). Leading edges are the changes to the asserted level. `hsync_o` and `vsync_o` repeat the input levels unchanged, with no inversion.
- R3: Pixel index 0 is the first sample where hsync is asserted after a sample where it was not. A pixel lies in the horizontal window for indices `H_SYNC+H_BP` through `H_SYNC+H_BP+H_ACTIVE-1` (260 to 1539 by default), so a locked line has exactly `H_ACTIVE` active clocks.
- R4: Vsync is sampled at each hsync leading edge. Line 0 is the line whose edge finds vsync asserted after the previous edge found it deasserted. The vertical window covers lines `V_SYNC+V_BP` through `V_SYNC+V_BP+V_ACTIVE-1` (25 to 744 by default).
- R5: `active_o` for a pixel is high exactly when the pixel is inside both windows and the lock state was set before that pixel, meaning `locked_o` in the preceding output cycle. While unlocked, `active_o` stays low.
- R6: The first vsync leading edge after reset starts measurement and closes no frame. Each later vsync edge closes a frame. A frame is good when every line closed inside it lasted `H_TOTAL` clocks, no overrun occurred, and it held `V_TOTAL` lines. `locked_o` goes high in the output cycle of the pixel that closes the `LOCK_FRAMES`-th consecutive good frame. With the default of 2, that is the third vsync edge of a clean stream.
- R7: Lock drops in the output cycle of the offending pixel when an hsync edge closes a line whose length is not `H_TOTAL` clocks. It also drops when a line reaches pixel index `H_TOTAL` with no edge. The frame holding that line does not count as good.
- R8: Lock drops at the hsync edge of a line whose index reaches `V_TOTAL` without a vsync edge. It also drops when a vsync edge closes a frame whose line count is not `V_TOTAL`. In both cases the good-frame count restarts from zero.
- R9: A synchronous active-high reset clears all counters and the lock state. While it holds, `rgb_o` is 0, `active_o` and `locked_o` are 0, and both sync outputs sit at the deasserted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | Horizontal sync from the source |
| vsync_i | input | 1 | Vertical sync from the source |
| rgb_i | input | 3*COMP_W (24) | Pixel word: red in the top byte, then green, then blue |
| rgb_o | output | 3*COMP_W (24) | Pixel word, delayed two clocks |
| hsync_o | output | 1 | Horizontal sync, delayed two clocks, original polarity |
| vsync_o | output | 1 | Vertical sync, delayed two clocks, original polarity |
| active_o | output | 1 | Rebuilt active-video flag, aligned with `rgb_o` |
| locked_o | output | 1 | Incoming timing matches the programmed totals |

## Verification
The assertions assume a source whose sync pulses match the programmed widths. They also assume that vsync changes only at hsync leading edges. Only under those conditions does a locked `active_o` never coincide with an asserted sync output, and no run of active clocks exceed `H_ACTIVE`. The stimulus builds every line and frame from the same small set of timing parameters as the device under test. Its faults change only line and frame lengths, never sync pulse widths or where vsync changes, so these assumptions hold throughout while the lock logic is still stressed.

// File: rtl/vtr_pkg.sv
package vtr_pkg;

  // Saturating counter width able to hold TOTAL plus an overrun margin.
  function automatic int ctr_width(input int total);
    return $clog2(total + 1) + 1;
  endfunction

  // True when pos lies in [lo, lo+len).
  function automatic logic in_span(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  typedef struct packed {
    logic hs;
    logic vs;
  } vtr_sync_t;

endpackage

// File: rtl/vtr_in_stage.sv
module vtr_in_stage
  import vtr_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter bit SYNC_POL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] rgb_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [PIX_W-1:0] rgb_s1,
  output vtr_sync_t        raw_s1,
  output logic             h_lead,
  output logic             v_lead
);

  logic hs_on, vs_on;
  logic hs_prev;
  logic vs_at_h;

  // Normalised (asserted = 1) view of the registered syncs.
  assign hs_on  = (raw_s1.hs == SYNC_POL);
  assign vs_on  = (raw_s1.vs == SYNC_POL);
  assign h_lead = hs_on & ~hs_prev;
  assign v_lead = h_lead & vs_on & ~vs_at_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_s1  <= '0;
      raw_s1  <= '{hs: ~SYNC_POL, vs: ~SYNC_POL};
      hs_prev <= 1'b0;
      vs_at_h <= 1'b0;
    end else begin
      rgb_s1    <= rgb_i;
      raw_s1.hs <= hsync_i;
      raw_s1.vs <= vsync_i;
      hs_prev   <= hs_on;
      if (h_lead) vs_at_h <= vs_on;
    end
  end

endmodule

// File: rtl/vtr_span_ctr.sv
module vtr_span_ctr
  import vtr_pkg::*;
#(
  parameter int ACTIVE = 1280,
  parameter int SKIP   = 260,
  parameter int TOTAL  = 1650
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic lead,
  output logic win,
  output logic seen,
  output logic len_bad,
  output logic over
);

  localparam int CW = ctr_width(TOTAL);

  logic [CW-1:0] cnt_r, inc, pos;

  always_comb begin
    inc = (cnt_r == {CW{1'b1}}) ? cnt_r : cnt_r + CW'(1);
    if (lead)      pos = '0;
    else if (step) pos = inc;
    else           pos = cnt_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_r <= '0;
      seen  <= 1'b0;
    end else begin
      cnt_r <= pos;
      if (lead) seen <= 1'b1;
    end
  end

  assign win     = in_span(int'(pos), SKIP, ACTIVE);
  assign len_bad = lead & seen & (cnt_r != CW'(TOTAL - 1));
  assign over    = step & ~lead & seen & (inc == CW'(TOTAL));

endmodule

// File: rtl/vtr_lock.sv
module vtr_lock #(
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic v_lead,
  input  logic v_seen,
  input  logic line_bad,
  input  logic frame_len_bad,
  input  logic frame_over,
  output logic locked
);

  localparam int GW = $clog2(LOCK_FRAMES + 1);

  logic [GW-1:0] good_r;
  logic          dirty_r;
  logic          mid_bad, frame_bad;

  assign mid_bad   = line_bad | frame_over;
  assign frame_bad = frame_len_bad | dirty_r | line_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_r  <= '0;
      dirty_r <= 1'b0;
      locked  <= 1'b0;
    end else if (v_lead) begin
      dirty_r <= 1'b0;
      if (v_seen) begin
        if (frame_bad) begin
          good_r <= '0;
          locked <= 1'b0;
        end else begin
          if (good_r != GW'(LOCK_FRAMES)) good_r <= good_r + GW'(1);
          if (good_r >= GW'(LOCK_FRAMES - 1)) locked <= 1'b1;
        end
      end
    end else if (mid_bad) begin
      good_r  <= '0;
      dirty_r <= 1'b1;
      locked  <= 1'b0;
    end
  end

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(v_lead));

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mid_bad && !v_lead) |=> !locked);

  // R8
  frame_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (v_lead && v_seen && frame_len_bad) |=> !locked);

endmodule

// File: rtl/vtr_sync_recover.sv
module vtr_sync_recover
  import vtr_pkg::*;
#(
  parameter int COMP_W      = 8,
  parameter int H_ACTIVE    = 1280,
  parameter int H_FP        = 110,
  parameter int H_SYNC      = 40,
  parameter int H_BP        = 220,
  parameter int V_ACTIVE    = 720,
  parameter int V_FP        = 5,
  parameter int V_SYNC      = 5,
  parameter int V_BP        = 20,
  parameter bit SYNC_POL    = 1'b1,
  parameter int LOCK_FRAMES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hsync_i,
  input  logic                  vsync_i,
  input  logic [3*COMP_W-1:0]   rgb_i,
  output logic [3*COMP_W-1:0]   rgb_o,
  output logic                  hsync_o,
  output logic                  vsync_o,
  output logic                  active_o,
  output logic                  locked_o
);

  localparam int PIX_W   = 3 * COMP_W;
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;

  logic [PIX_W-1:0] rgb_s1;
  vtr_sync_t        raw_s1;
  logic             h_lead, v_lead;
  logic             h_win, h_seen, h_len_bad, h_over;
  logic             v_win, v_seen, v_len_bad, v_over;

  vtr_in_stage #(.PIX_W(PIX_W), .SYNC_POL(SYNC_POL)) u_in (
    .clk(clk), .rst(rst), .rgb_i(rgb_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .rgb_s1(rgb_s1), .raw_s1(raw_s1), .h_lead(h_lead), .v_lead(v_lead)
  );

  vtr_span_ctr #(.ACTIVE(H_ACTIVE), .SKIP(H_SYNC + H_BP), .TOTAL(H_TOTAL)) u_hctr (
    .clk(clk), .rst(rst), .step(1'b1), .lead(h_lead),
    .win(h_win), .seen(h_seen), .len_bad(h_len_bad), .over(h_over)
  );

  vtr_span_ctr #(.ACTIVE(V_ACTIVE), .SKIP(V_SYNC + V_BP), .TOTAL(V_TOTAL)) u_vctr (
    .clk(clk), .rst(rst), .step(h_lead), .lead(v_lead),
    .win(v_win), .seen(v_seen), .len_bad(v_len_bad), .over(v_over)
  );

  vtr_lock #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk), .rst(rst), .v_lead(v_lead), .v_seen(v_seen & h_seen),
    .line_bad(h_len_bad | h_over), .frame_len_bad(v_len_bad),
    .frame_over(v_over), .locked(locked_o)
  );

  // Output stage: every stream signal passes one more register here.
  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_o    <= '0;
      hsync_o  <= ~SYNC_POL;
      vsync_o  <= ~SYNC_POL;
      active_o <= 1'b0;
    end else begin
      rgb_o    <= rgb_s1;
      hsync_o  <= raw_s1.hs;
      vsync_o  <= raw_s1.vs;
      active_o <= h_win & v_win & locked_o;
    end
  end

  // Run-length counter of consecutive active outputs, used by the check below.
  localparam int RW = $clog2(H_ACTIVE + 2);
  logic [RW-1:0] run_r;
  always_ff @(posedge clk) begin
    if (rst || !active_o) run_r <= '0;
    else if (run_r != {RW{1'b1}}) run_r <= run_r + RW'(1);
  end

  // R5
  act_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> $past(locked_o));

  // R3
  act_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> ((hsync_o != SYNC_POL) && (vsync_o != SYNC_POL)));

  // R3
  act_run_len_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (run_r < RW'(H_ACTIVE)));

endmodule

// File: tb/vtr_sync_recover_tb_top.sv
module vtr_sync_recover_tb_top;

  localparam int HA = 8, HF = 2, HS = 2, HB = 3;
  localparam int VA = 4, VF = 1, VS = 2, VB = 2;
  localparam int LF = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic        clk = 1'b0, rst = 1'b1;
  logic        hs_d = 1'b1, vs_d = 1'b1;
  logic [23:0] rgb_d = '0;
  logic [23:0] rgb_p, rgb_n;
  logic        hs_p, vs_p, act_p, lk_p;
  logic        hs_n, vs_n, act_n, lk_n;

  vtr_sync_recover #(
    .COMP_W(8), .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .SYNC_POL(1'b1), .LOCK_FRAMES(LF)
  ) dut_i (
    .clk(clk), .rst(rst), .hsync_i(hs_d), .vsync_i(vs_d), .rgb_i(rgb_d),
    .rgb_o(rgb_p), .hsync_o(hs_p), .vsync_o(vs_p), .active_o(act_p), .locked_o(lk_p)
  );

  vtr_sync_recover #(
    .COMP_W(8), .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .SYNC_POL(1'b0), .LOCK_FRAMES(LF)
  ) dut_n (
    .clk(clk), .rst(rst), .hsync_i(~hs_d), .vsync_i(~vs_d), .rgb_i(rgb_d),
    .rgb_o(rgb_n), .hsync_o(hs_n), .vsync_o(vs_n), .active_o(act_n), .locked_o(lk_n)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [23:0] rgb;
    logic        hs;
    logic        vs;
    logic        act;
    logic        lk;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   checks = 0, errors = 0;
  bit   mon_on = 1'b0, done = 1'b0;

  // Reference model state, built from the requirements.
  bit lock_m = 0, dirty_m = 0, seen_h = 0, seen_v = 0;
  int good_m = 0, cur_len = 0, last_y = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per output cycle and compares.
  always @(posedge clk) begin
    #2;
    if (mon_on && q.size() >= 2) begin
      mon_e = q.pop_front();
      chk(rgb_p == mon_e.rgb, "R1", "rgb", int'(rgb_p), int'(mon_e.rgb));
      chk(rgb_n == mon_e.rgb, "R1", "rgb low-pol", int'(rgb_n), int'(mon_e.rgb));
      chk(hs_p == mon_e.hs, "R2", "hsync", int'(hs_p), int'(mon_e.hs));
      chk(vs_p == mon_e.vs, "R2", "vsync", int'(vs_p), int'(mon_e.vs));
      chk(hs_n == !mon_e.hs, "R2", "hsync low-pol", int'(hs_n), int'(!mon_e.hs));
      chk(vs_n == !mon_e.vs, "R2", "vsync low-pol", int'(vs_n), int'(!mon_e.vs));
      chk(act_p == mon_e.act, "R3 R4 R5", "active", int'(act_p), int'(mon_e.act));
      chk(act_n == mon_e.act, "R2", "active low-pol", int'(act_n), int'(mon_e.act));
      chk(lk_p == mon_e.lk, "R6 R7 R8", "locked", int'(lk_p), int'(mon_e.lk));
      chk(lk_n == mon_e.lk, "R2", "locked low-pol", int'(lk_n), int'(mon_e.lk));
    end
  end

  task automatic mid_fault();
    good_m  = 0;
    lock_m  = 0;
    dirty_m = 1;
  endtask

  // Driver: one pixel at line position x of line y.
  task automatic px(input int x, input int y);
    bit   h_on, v_on, act, lbad;
    exp_t e;
    h_on = (x < HS);
    v_on = (y < VS);
    act  = lock_m && (x >= HS + HB) && (x < HS + HB + HA) &&
           (y >= VS + VB) && (y < VS + VB + VA);
    if (x == 0) begin
      lbad = seen_h && (cur_len != HT);
      if (y == 0) begin
        if (seen_v) begin
          if ((last_y + 1 != VT) || dirty_m || lbad) begin
            good_m = 0;
            lock_m = 0;
          end else begin
            if (good_m < LF) good_m++;
            if (good_m >= LF) lock_m = 1;
          end
        end
        dirty_m = 0;
        seen_v  = 1;
      end else if (lbad || (seen_v && y == VT)) begin
        mid_fault();
      end
      seen_h  = 1;
      cur_len = 1;
      last_y  = y;
    end else begin
      cur_len++;
      if (seen_h && x == HT) mid_fault();
    end
    @(negedge clk);
    rst   = 1'b0;
    hs_d  = h_on;
    vs_d  = v_on;
    rgb_d = 24'($urandom());
    e.rgb = rgb_d;
    e.hs  = h_on;
    e.vs  = v_on;
    e.act = act;
    e.lk  = lock_m;
    q.push_back(e);
  endtask

  // A frame of nl lines; line sy is one clock short, line ly two clocks long.
  task automatic send_frame(input int nl, input int sy, input int ly);
    for (int y = 0; y < nl; y++) begin
      int len;
      len = HT;
      if (y == sy) len = HT - 1;
      if (y == ly) len = HT + 2;
      for (int x = 0; x < len; x++) px(x, y);
    end
  endtask

  task automatic good_frames(input int n);
    for (int i = 0; i < n; i++) send_frame(VT, -1, -1);
  endtask

  task automatic reset_state_check();
    chk(rgb_p == 24'd0, "R9", "rgb in reset", int'(rgb_p), 0);
    chk(act_p == 1'b0, "R9", "active in reset", int'(act_p), 0);
    chk(lk_p == 1'b0, "R9", "locked in reset", int'(lk_p), 0);
    chk(hs_p == 1'b0 && vs_p == 1'b0, "R9", "syncs in reset", int'({hs_p, vs_p}), 0);
    chk(hs_n == 1'b1 && vs_n == 1'b1, "R9", "low-pol syncs in reset", int'({hs_n, vs_n}), 3);
    chk(lk_n == 1'b0 && act_n == 1'b0, "R9", "low-pol flags in reset", int'({lk_n, act_n}), 0);
  endtask

  initial begin
    rgb_d = 24'h5a5a5a;
    repeat (4) @(negedge clk);
    reset_state_check();
    mon_on = 1'b1;
    good_frames(4);                   // R6: lock from the third vsync edge
    send_frame(VT, 5, -1);            // R7: short line in an active line
    good_frames(3);
    send_frame(VT, -1, 6);            // R7: long line, overrun without edge
    good_frames(3);
    send_frame(VT + 1, -1, -1);       // R8: extra line
    good_frames(3);
    send_frame(VT - 1, -1, -1);       // R8: frame one line short
    good_frames(3);
    px(0, 0);
    px(1, 0);
    px(2, 0);
    @(negedge clk);
    chk(lk_p == 1'b1, "R6", "locked after clean frames", int'(lk_p), 1);
    mon_on = 1'b0;
    rst    = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reset_state_check();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule